// File: doc/BRIEF.md
# Software Interrupt Dispatch Unit

This block sits behind the distributor's write bus and turns one write to a write-only doorbell register into set-pending events on up to eight CPU interfaces. The written word selects an interrupt ID (0 to 15), a routing mode, a CPU bitmap and a requested group. The block merges these with the index and security state of the writing CPU and with a per-ID group configuration, then sets one pending bit per selected CPU.

A pending bit stays up until its CPU acknowledges that same ID. Priority arbitration, the CPU-side acknowledge handshake and the remaining distributor registers live elsewhere. The doorbell has no read path, and nothing of a written word is kept once it has been acted on.

Top module: `swi_dispatch`

## Requirements
- R1: After a synchronous active-low reset every pending bit of every CPU is clear.
- R2: A write acts only when `wr_valid` is high and `wr_addr` equals the doorbell offset (0xF00 by default). Writes to any other offset and idle cycles with that offset on the bus set no pending bit.
- R3: Routing mode 0b00 (word bits 25:24) sets the ID on each CPU whose bitmap bit is set. Word bit 16+n selects CPU n. Bitmap bits of CPUs at or above `NUM_CPU` are ignored.
- R4: Routing mode 0b01 sets the ID on every implemented CPU except the one given on `wr_cpu`. A writer index at or above `NUM_CPU` excludes nobody.
- R5: Routing mode 0b10 sets the ID only on the CPU given on `wr_cpu`. If that index is not implemented, nothing is set.
- R6: Routing mode 0b11 sets no pending bit.
- R7: On a secure write (`wr_secure`=1), the ID is forwarded only if `grp_cfg[id]` equals word bit 15. Here 0 means Group 0 and 1 means Group 1.
- R8: On a non-secure write, the ID is forwarded only if `grp_cfg[id]` is 1, whatever word bit 15 holds.
- R9: Word bits 14:4 and 31:26 have no effect on the outcome. The ID is word bits 3:0.
- R10: A pending bit set by a write is visible in the cycle after the write. It stays set until its CPU drives `ack_valid` with the same ID on `ack_id`. The clear is visible one cycle after that acknowledge, and an acknowledge of a different ID leaves it set.
- R11: When a write sets, and an acknowledge clears, the same CPU and ID in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write strobe, always accepted in its cycle |
| wr_addr | input | ADDR_W | Byte offset of the write in distributor space |
| wr_data | input | 32 | Write data word |
| wr_cpu | input | 3 | Index of the CPU performing the write |
| wr_secure | input | 1 | 1 for a secure access |
| grp_cfg | input | NUM_ID | Group of each ID, 1 = Group 1 |
| ack_valid | input | NUM_CPU | Per-CPU acknowledge strobe |
| ack_id | input | NUM_CPU*4 | Per-CPU acknowledged ID, CPU n in bits 4n+3:4n |
| pend | output | NUM_CPU*NUM_ID | Pending bits, CPU n ID k at bit 16n+k |

## Verification
The bench runs with six implemented CPUs, so bitmap bits 6 and 7 and writer index 7 exercise the unimplemented-CPU cases. Bitmap writes with sparse and saturated maps separate mode 0b00 from the broadcast modes. Broadcast-except and self writes from an implemented writer and from an absent one show whether the writer index is excluded or included as required. Each secure and non-secure write is paired against both group settings with both attribute values, which exposes a gate that ignores the security flag or reads the wrong bit. Reserved-bit noise, off-offset writes, stray acknowledges and a same-cycle set and clear then confirm that only the intended fields and IDs move a pending bit.

// File: rtl/swi_pkg.sv
// Shared constants and types for the software interrupt dispatch unit.
// Assumes a 32-bit doorbell word and a 4-bit interrupt ID.
package swi_pkg;
    localparam int WORD_W    = 32;
    localparam int ID_W      = 4;
    localparam int NUM_ID    = 1 << ID_W;
    localparam int MAX_CPU   = 8;
    localparam int CPU_IDX_W = 3;

    // Bit positions inside the doorbell word
    localparam int ID_LSB    = 0;
    localparam int ATTR_BIT  = 15;
    localparam int MAP_LSB   = 16;
    localparam int MODE_LSB  = 24;

    typedef enum logic [1:0] {
        ROUTE_LIST   = 2'b00,
        ROUTE_OTHERS = 2'b01,
        ROUTE_SELF   = 2'b10,
        ROUTE_NONE   = 2'b11
    } route_mode_e;

    typedef struct packed {
        logic                 hit;
        route_mode_e          mode;
        logic [MAX_CPU-1:0]   cpu_map;
        logic                 grp1_req;
        logic [ID_W-1:0]      sgi_id;
        logic [CPU_IDX_W-1:0] src_cpu;
        logic                 secure;
    } swi_req_t;
endpackage

// File: rtl/swi_decode.sv
// Address match and field extraction for the doorbell word.
// Purely combinational; reserved word bits are dropped here.
module swi_decode
    import swi_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hF00
) (
    input  logic                 wr_valid,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [CPU_IDX_W-1:0] wr_cpu,
    input  logic                 wr_secure,
    output swi_req_t             req
);
    logic unused_rsvd;

    // Parity of reserved bits, kept only so every input bit has a reader
    assign unused_rsvd = ^{wr_data[WORD_W-1:MODE_LSB+2], wr_data[ATTR_BIT-1:ID_LSB+ID_W]};

    // Split the word into its routing fields
    always_comb begin
        req.hit      = wr_valid && (wr_addr == REG_OFFSET);
        req.mode     = route_mode_e'(wr_data[MODE_LSB +: 2]);
        req.cpu_map  = wr_data[MAP_LSB +: MAX_CPU];
        req.grp1_req = wr_data[ATTR_BIT];
        req.sgi_id   = wr_data[ID_LSB +: ID_W];
        req.src_cpu  = wr_cpu;
        req.secure   = wr_secure;
    end
endmodule

// File: rtl/swi_route.sv
// Target selection and group gating for one decoded doorbell write.
// Produces a per-CPU set strobe; assumes 1 <= NUM_CPU <= 8.
module swi_route
    import swi_pkg::*;
#(
    parameter int NUM_CPU = 8
) (
    input  swi_req_t           req,
    input  logic [NUM_ID-1:0]  grp_cfg,
    output logic [NUM_CPU-1:0] set_mask
);
    logic [NUM_CPU-1:0] src_hot;
    logic [NUM_CPU-1:0] cand;
    logic               cfg_grp1;
    logic               grp_ok;
    logic [MAX_CPU-1:0] unused_map;

    // One-hot of the writer, empty when the writer is not implemented
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_src
        assign src_hot[c] = (req.src_cpu == CPU_IDX_W'(c));
    end

    // Bitmap bits for absent CPUs are discarded
    assign unused_map = req.cpu_map;

    // Candidate CPUs from the routing mode
    always_comb begin
        unique case (req.mode)
            ROUTE_LIST:   cand = req.cpu_map[NUM_CPU-1:0];
            ROUTE_OTHERS: cand = ~src_hot;
            ROUTE_SELF:   cand = src_hot;
            default:      cand = '0;
        endcase
    end

    // Group gate: secure writes must match, non-secure need Group 1
    always_comb begin
        cfg_grp1 = grp_cfg[req.sgi_id];
        grp_ok   = req.secure ? (cfg_grp1 == req.grp1_req) : cfg_grp1;
    end

    assign set_mask = (req.hit && grp_ok) ? cand : '0;
endmodule

// File: rtl/swi_pend_bank.sv
// Pending bits of one CPU interface, one per interrupt ID.
// A set in the same cycle as a clear of the same ID wins.
module swi_pend_bank
    import swi_pkg::*;
#(
    parameter int N_ID = NUM_ID,
    localparam int IW  = $clog2(N_ID)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IW-1:0]   set_id,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_id,
    output logic [N_ID-1:0] pend
);
    logic [N_ID-1:0] pend_nxt;

    // Next state: clear first, then set so that set has priority
    always_comb begin
        pend_nxt = pend;
        if (clr_en) pend_nxt[clr_id] = 1'b0;
        if (set_en) pend_nxt[set_id] = 1'b1;
    end

    // Pending register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= pend_nxt;
    end
endmodule

// File: rtl/swi_dispatch.sv
// Top of the software interrupt dispatch unit: decode, route, and
// one pending bank per implemented CPU. No backpressure on writes.
module swi_dispatch
    import swi_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hF00,
    parameter int                NUM_CPU    = 8,
    localparam int               PEND_W     = NUM_CPU * NUM_ID
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic [CPU_IDX_W-1:0]    wr_cpu,
    input  logic                    wr_secure,
    input  logic [NUM_ID-1:0]       grp_cfg,
    input  logic [NUM_CPU-1:0]      ack_valid,
    input  logic [NUM_CPU*ID_W-1:0] ack_id,
    output logic [PEND_W-1:0]       pend
);
    swi_req_t           req;
    logic [NUM_CPU-1:0] set_mask;

    swi_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_decode (
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_cpu   (wr_cpu),
        .wr_secure(wr_secure),
        .req      (req)
    );

    swi_route #(.NUM_CPU(NUM_CPU)) u_route (
        .req     (req),
        .grp_cfg (grp_cfg),
        .set_mask(set_mask)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        swi_pend_bank #(.N_ID(NUM_ID)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .set_en(set_mask[c]),
            .set_id(req.sgi_id),
            .clr_en(ack_valid[c]),
            .clr_id(ack_id[c*ID_W +: ID_W]),
            .pend  (pend[c*NUM_ID +: NUM_ID])
        );
    end
endmodule

// File: rtl/swi_dispatch_chk.sv
// Protocol checker for swi_dispatch, attached by bind below.
module swi_dispatch_chk
    import swi_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'hF00,
    parameter int                NUM_CPU    = 8,
    localparam int               PEND_W     = NUM_CPU * NUM_ID
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_valid,
    input logic [ADDR_W-1:0]       wr_addr,
    input logic [WORD_W-1:0]       wr_data,
    input logic [CPU_IDX_W-1:0]    wr_cpu,
    input logic                    wr_secure,
    input logic [NUM_ID-1:0]       grp_cfg,
    input logic [NUM_CPU-1:0]      ack_valid,
    input logic [NUM_CPU*ID_W-1:0] ack_id,
    input logic [PEND_W-1:0]       pend
);
    logic [PEND_W-1:0]  prev_pend, id_rep, ack_allow, rise, fall;
    logic [NUM_CPU-1:0] last_src_hot, cpu_rise;
    logic               hit;

    assign hit  = wr_valid && (wr_addr == REG_OFFSET);
    assign rise = pend & ~prev_pend;
    assign fall = prev_pend & ~pend;

    // Remember last cycle's pending state, ID, writer and acknowledges
    always_ff @(posedge clk) begin
        prev_pend <= pend;
        for (int c = 0; c < NUM_CPU; c++) begin
            id_rep[c*NUM_ID +: NUM_ID]    <= NUM_ID'(1) << wr_data[ID_LSB +: ID_W];
            ack_allow[c*NUM_ID +: NUM_ID] <= ack_valid[c] ?
                (NUM_ID'(1) << ack_id[c*ID_W +: ID_W]) : '0;
            last_src_hot[c]               <= (wr_cpu == CPU_IDX_W'(c));
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_rise
        assign cpu_rise[c] = |rise[c*NUM_ID +: NUM_ID];
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend == '0));
    assert_quiet_offaddr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (rise == '0));
    assert_others_skip_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data[MODE_LSB +: 2] == 2'b01) |=> ((cpu_rise & last_src_hot) == '0));
    assert_self_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data[MODE_LSB +: 2] == 2'b10) |=> ((cpu_rise & ~last_src_hot) == '0));
    assert_rsvd_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_data[MODE_LSB +: 2] == 2'b11) |=> (rise == '0));
    assert_nonsec_grp0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_secure && !grp_cfg[wr_data[ID_LSB +: ID_W]]) |=> (rise == '0));
    assert_single_id_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ((rise & ~id_rep) == '0));
    assert_clear_by_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) || ((fall & ~ack_allow) == '0));
endmodule

bind swi_dispatch swi_dispatch_chk #(
    .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .NUM_CPU(NUM_CPU)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_cpu(wr_cpu), .wr_secure(wr_secure),
    .grp_cfg(grp_cfg), .ack_valid(ack_valid), .ack_id(ack_id), .pend(pend)
);

// File: tb/swi_dispatch_bench.sv
// Bench: behavioural reference model compared on every clock.
module swi_dispatch_bench;
    localparam int NC = 6;
    localparam int NI = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [2:0]    wr_cpu = '0;
    logic          wr_secure = 1'b0;
    logic [15:0]   grp_cfg = 16'hA5A5;
    logic [NC-1:0] ack_valid = '0;
    logic [NC*4-1:0] ack_id = '0;
    logic [NC*NI-1:0] pend;

    int    checks = 0;
    int    fails = 0;
    bit    live = 1'b0;
    string cur_req = "R1";
    logic [15:0] model [NC];

    always #5 clk = ~clk;

    swi_dispatch #(.NUM_CPU(NC)) u_swi_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_cpu(wr_cpu), .wr_secure(wr_secure),
        .grp_cfg(grp_cfg), .ack_valid(ack_valid), .ack_id(ack_id), .pend(pend)
    );

    // Reference model, advanced at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NC; c++) model[c] = '0;
        end else begin
            for (int c = 0; c < NC; c++)
                if (ack_valid[c]) model[c][ack_id[c*4 +: 4]] = 1'b0;
            if (wr_valid && wr_addr == 12'hF00) begin
                int  id;
                int  f;
                bit  ok;
                id = int'(wr_data[3:0]);
                f  = int'(wr_data[25:24]);
                ok = wr_secure ? (grp_cfg[id] == wr_data[15]) : grp_cfg[id];
                for (int c = 0; c < NC; c++) begin
                    bit t;
                    case (f)
                        0: t = wr_data[16 + c];
                        1: t = (c != int'(wr_cpu));
                        2: t = (c == int'(wr_cpu));
                        default: t = 1'b0;
                    endcase
                    if (ok && t) model[c][id] = 1'b1;
                end
            end
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (live) begin
            for (int c = 0; c < NC; c++) begin
                checks++;
                if (pend[c*NI +: NI] !== model[c]) begin
                    fails++;
                    $display("FAIL %s cpu%0d pend actual=%h expected=%h",
                             cur_req, c, pend[c*NI +: NI], model[c]);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d,
                      input int cpu, input bit sec);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        wr_cpu = 3'(cpu); wr_secure = sec;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    function automatic logic [31:0] word(int mode, logic [7:0] map, bit attr, int id);
        return {6'b0, 2'(mode), map, attr, 11'b0, 4'(id)};
    endfunction

    task automatic expect_cpu(int c, logic [15:0] exp, string req);
        checks++;
        if (pend[c*NI +: NI] !== exp) begin
            fails++;
            $display("FAIL %s cpu%0d actual=%h expected=%h", req, c, pend[c*NI +: NI], exp);
        end
    endtask

    task automatic clear_all();
        for (int id = 0; id < NI; id++) begin
            @(negedge clk);
            ack_valid = '1;
            for (int c = 0; c < NC; c++) ack_id[c*4 +: 4] = 4'(id);
        end
        @(negedge clk);
        ack_valid = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired in %s", cur_req);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        live = 1'b1;
        for (int c = 0; c < NC; c++) expect_cpu(c, 16'h0000, "R1");

        // grp_cfg 0xA5A5: IDs 0,2,5,7,8,10,13,15 are Group 1
        cur_req = "R3";
        wr(12'hF00, word(0, 8'b1100_0101, 1, 0), 0, 1);
        expect_cpu(0, 16'h0001, "R3");
        expect_cpu(2, 16'h0001, "R3");
        expect_cpu(1, 16'h0000, "R3");
        wr(12'hF00, word(0, 8'hFF, 1, 2), 3, 1);
        clear_all();

        cur_req = "R4";
        wr(12'hF00, word(1, 8'h00, 1, 2), 3, 1);
        expect_cpu(3, 16'h0000, "R4");
        expect_cpu(5, 16'h0004, "R4");
        wr(12'hF00, word(1, 8'h00, 1, 5), 7, 1);
        expect_cpu(3, 16'h0020, "R4");
        clear_all();

        cur_req = "R5";
        wr(12'hF00, word(2, 8'hFF, 1, 5), 4, 1);
        expect_cpu(4, 16'h0020, "R5");
        expect_cpu(0, 16'h0000, "R5");
        wr(12'hF00, word(2, 8'h00, 1, 7), 7, 1);
        clear_all();

        cur_req = "R6";
        wr(12'hF00, word(3, 8'hFF, 1, 0), 1, 1);
        wr(12'hF00, word(3, 8'hFF, 0, 1), 1, 0);
        expect_cpu(1, 16'h0000, "R6");

        cur_req = "R7";
        wr(12'hF00, word(0, 8'h01, 0, 1), 0, 1);
        expect_cpu(0, 16'h0002, "R7");
        wr(12'hF00, word(0, 8'h02, 1, 1), 0, 1);
        wr(12'hF00, word(0, 8'h02, 0, 0), 0, 1);
        expect_cpu(1, 16'h0000, "R7");
        wr(12'hF00, word(0, 8'h02, 1, 0), 0, 1);
        expect_cpu(1, 16'h0001, "R7");
        clear_all();

        cur_req = "R8";
        wr(12'hF00, word(0, 8'h3F, 0, 1), 2, 0);
        wr(12'hF00, word(0, 8'h3F, 1, 3), 2, 0);
        expect_cpu(2, 16'h0000, "R8");
        wr(12'hF00, word(0, 8'h04, 0, 7), 2, 0);
        expect_cpu(2, 16'h0080, "R8");
        clear_all();

        cur_req = "R9";
        wr(12'hF00, word(0, 8'h08, 1, 10) | 32'hFC00_7FF0, 1, 1);
        expect_cpu(3, 16'h0400, "R9");
        clear_all();

        cur_req = "R2";
        wr(12'hF04, word(0, 8'h3F, 1, 0), 0, 1);
        wr(12'hE00, word(2, 8'h00, 1, 0), 0, 1);
        @(negedge clk);
        wr_addr = 12'hF00; wr_data = word(0, 8'h3F, 1, 0); wr_secure = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NC; c++) expect_cpu(c, 16'h0000, "R2");

        cur_req = "R10";
        wr(12'hF00, word(0, 8'h01, 1, 13), 0, 1);
        @(negedge clk);
        ack_valid = 6'b000001; ack_id = '0; ack_id[3:0] = 4'd12;
        @(negedge clk);
        ack_valid = '0;
        expect_cpu(0, 16'h2000, "R10");
        @(negedge clk);
        ack_valid = 6'b000001; ack_id[3:0] = 4'd13;
        @(negedge clk);
        ack_valid = '0;
        expect_cpu(0, 16'h0000, "R10");

        cur_req = "R11";
        wr(12'hF00, word(0, 8'h02, 1, 8), 0, 1);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = 12'hF00; wr_data = word(0, 8'h02, 1, 8);
        wr_secure = 1'b1;
        ack_valid = 6'b000010; ack_id[7:4] = 4'd8;
        @(negedge clk);
        wr_valid = 1'b0; ack_valid = '0;
        expect_cpu(1, 16'h0100, "R11");
        @(negedge clk);
        wr_valid = 1'b1; ack_valid = 6'b000010;
        @(negedge clk);
        wr_valid = 1'b0; ack_valid = '0;
        expect_cpu(1, 16'h0100, "R11");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule